// File: doc/BRIEF.md
# Lazy Coprocessor Context-Switch Controller

This block decides when the architectural state of a numeric coprocessor has to move between memory and the coprocessor. A task switch leaves the coprocessor untouched and only raises a task-switched flag. The coprocessor state is moved later, and only if it has to be. When a task then issues a wait or escape instruction while the flag is up, the controller signals a not-present exception. It clears the flag with interrupts held off and compares the task that owns the coprocessor with the task now running.

If the two task IDs are equal, the sequence ends with no data movement. If they differ, the controller runs a save of the owner's coprocessor state into the owner's save area, then a restore of the running task's state from that task's save area. It then records the running task as the new owner. Each save area starts at `task_id << STRIDE_LOG2`. Within an area, the coprocessor state sits after 44 bytes of CPU state and takes 47 sixteen-bit words. A numeric error is tagged with the task that owned the coprocessor when the error arrived. It is reported only when that same task reaches a wait or escape instruction with the flag clear.

Top module: `cop_ctx_lazy`

## Requirements
- R1: A one-cycle `task_switch_i` sets `ts_flag_o` on the next clock edge. Only the controller's check step clears the flag. If a task switch and the check step fall in the same cycle, the flag stays set.
- R2: `cop_instr_i` in the idle state with `ts_flag_o` set gives `exc_o`=1 with `exc_vec_o`=7 for exactly the next cycle. From that cycle until `done_o`, `intr_en_o` is 0.
- R3: In the cycle where `exc_o`/7 is shown, the flag is cleared (it reads 0 from the following cycle, unless R1's collision applies). If `owner_o` equals the task ID captured with the instruction, no transfer is requested and `done_o` follows in the next cycle.
- R4: If the owner differs, 47 save transfers are issued with `xfer_wr_o`=1. Their addresses are `owner*256 + 44 + 2*i` for i = 0..46, in ascending order.
- R5: The restore transfers (`xfer_wr_o`=0) begin only after the last save word is acknowledged. There are 47 of them, at `task*256 + 44 + 2*i` in ascending order.
- R6: A word completes only on a cycle with `xfer_req_o` and `xfer_ack_i` both high. While a request waits, its address and direction hold.
- R7: After the last restore word is acknowledged, `owner_o` equals the running task's ID. `done_o` pulses in the next cycle.
- R8: `done_o` lasts one cycle. `intr_en_o` returns to 1 in the cycle after it.
- R9: A `cop_err_i` pulse is tagged with the current owner. It is reported as `exc_o`=1, `exc_vec_o`=16 for one cycle only after a `cop_instr_i` with the flag clear from the tagged task, and is then cleared. Instructions from other tasks leave it pending.
- R10: `cop_instr_i` is ignored while a sequence is running.
- R11: After reset, `ts_flag_o`=0, `owner_o`=0, `intr_en_o`=1, and `xfer_req_o`, `exc_o` and `done_o` are 0.
- R12: `cop_instr_i` with the flag clear and no matching pending error raises no exception and no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| task_switch_i | input | 1 | Pulse: a task switch occurred |
| cur_task_i | input | TASK_W | ID of the running task |
| cop_instr_i | input | 1 | Pulse: a wait or escape instruction starts |
| cop_err_i | input | 1 | Pulse: the coprocessor reports a numeric error |
| xfer_ack_i | input | 1 | Acknowledge for the current transfer word |
| ts_flag_o | output | 1 | Task-switched flag |
| owner_o | output | TASK_W | Task that owns the coprocessor state |
| exc_o | output | 1 | Exception strobe |
| exc_vec_o | output | 8 | Exception vector: 7 not present, 16 numeric |
| intr_en_o | output | 1 | Interrupts allowed |
| xfer_req_o | output | 1 | Transfer word request |
| xfer_wr_o | output | 1 | 1 = save to memory, 0 = restore |
| xfer_addr_o | output | TASK_W+STRIDE_LOG2 | Byte address of the word |
| done_o | output | 1 | Pulse: handler sequence finished |

## Verification
The embedded properties check the following on every cycle:
- setting and clearing of the flag, including the priority of a set over a clear;
- the one-cycle exception after a qualifying instruction;
- that a pending request and its address hold until acknowledged;
- the switch from save to restore on the last save acknowledge;
- the owner update;
- the single-cycle `done_o`.

Only the bench scenarios can show the full address order of both transfer phases under varying acknowledge latency. The same holds for the no-transfer path when the owner matches and for an instruction ignored in mid-sequence. The error deferral also needs a scenario: an error stays pending across another task's turn and fires once when its own task returns.

// File: rtl/cop_ctx_pkg.sv
package cop_ctx_pkg;

    localparam int unsigned CPU_CTX_BYTES   = 44;
    localparam int unsigned COP_CTX_WORDS   = 47;
    localparam int unsigned WORD_BYTES      = 2;
    localparam int unsigned CNT_W           = $clog2(COP_CTX_WORDS);
    localparam logic [7:0]  VEC_NOT_PRESENT = 8'd7;
    localparam logic [7:0]  VEC_NUMERIC     = 8'd16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SAVE,
        ST_RESTORE,
        ST_DONE,
        ST_NERR
    } seq_state_e;

    typedef struct packed {
        logic clr_flag;
        logic take_err;
        logic cnt_clr;
        logic owner_load;
    } seq_ctl_t;

    function automatic logic [CNT_W-1:0] last_word();
        return CNT_W'(COP_CTX_WORDS - 1);
    endfunction

endpackage

// File: rtl/cop_ts_flag.sv
module cop_ts_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    // R1
    ts_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);

    // R3
    ts_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/cop_owner_track.sv
module cop_owner_track #(
    parameter int unsigned TASK_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [TASK_W-1:0] load_tid_i,
    input  logic              err_i,
    input  logic              take_i,
    input  logic [TASK_W-1:0] cur_task_i,
    output logic [TASK_W-1:0] owner_o,
    output logic              err_hit_o
);
    logic              err_pend_q;
    logic [TASK_W-1:0] err_tag_q;

    always_ff @(posedge clk) begin
        if (rst)         owner_o <= '0;
        else if (load_i) owner_o <= load_tid_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_pend_q <= 1'b0;
            err_tag_q  <= '0;
        end else begin
            if (take_i) err_pend_q <= 1'b0;
            if (err_i && (!err_pend_q || take_i)) begin
                err_pend_q <= 1'b1;
                err_tag_q  <= owner_o;
            end
        end
    end

    assign err_hit_o = err_pend_q && (err_tag_q == cur_task_i);

    // R7
    owner_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (owner_o == $past(load_tid_i)));

    // R9
    err_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (err_i && !take_i) |=> err_pend_q);
endmodule

// File: rtl/cop_xfer_agu.sv
module cop_xfer_agu
    import cop_ctx_pkg::*;
#(
    parameter int unsigned TASK_W      = 4,
    parameter int unsigned STRIDE_LOG2 = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr_i,
    input  logic                          adv_i,
    input  logic [TASK_W-1:0]             tid_i,
    output logic                          last_o,
    output logic [TASK_W+STRIDE_LOG2-1:0] addr_o
);
    localparam int unsigned ADDR_W = TASK_W + STRIDE_LOG2;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)  cnt_q <= '0;
        else if (adv_i)    cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end

    assign last_o = (cnt_q == last_word());
    assign addr_o = {tid_i, STRIDE_LOG2'(0)}
                  + ADDR_W'(CPU_CTX_BYTES)
                  + ADDR_W'(cnt_q) * ADDR_W'(WORD_BYTES);

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last_word());
endmodule

// File: rtl/cop_seq_fsm.sv
module cop_seq_fsm
    import cop_ctx_pkg::*;
#(
    parameter int unsigned TASK_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_i,
    input  logic              flag_i,
    input  logic [TASK_W-1:0] cur_task_i,
    input  logic [TASK_W-1:0] owner_i,
    input  logic              err_hit_i,
    input  logic              ack_i,
    input  logic              last_i,
    output seq_ctl_t          ctl_o,
    output logic [TASK_W-1:0] tid_o,
    output logic              exc_o,
    output logic [7:0]        exc_vec_o,
    output logic              intr_en_o,
    output logic              req_o,
    output logic              wr_o,
    output logic              done_o
);
    seq_state_e state_q, state_d;
    logic       word_end;

    assign word_end = ack_i && last_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (instr_i && flag_i)         state_d = ST_CHECK;
                else if (instr_i && err_hit_i) state_d = ST_NERR;
            end
            ST_CHECK:   state_d = (owner_i == tid_o) ? ST_DONE : ST_SAVE;
            ST_SAVE:    if (word_end) state_d = ST_RESTORE;
            ST_RESTORE: if (word_end) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            ST_NERR:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tid_o   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && instr_i && flag_i) tid_o <= cur_task_i;
        end
    end

    always_comb begin
        ctl_o            = '0;
        ctl_o.clr_flag   = (state_q == ST_CHECK);
        ctl_o.cnt_clr    = (state_q == ST_CHECK);
        ctl_o.take_err   = (state_q == ST_IDLE) && instr_i && !flag_i && err_hit_i;
        ctl_o.owner_load = (state_q == ST_RESTORE) && word_end;
    end

    assign exc_o     = (state_q == ST_CHECK) || (state_q == ST_NERR);
    assign exc_vec_o = (state_q == ST_CHECK) ? VEC_NOT_PRESENT :
                       (state_q == ST_NERR)  ? VEC_NUMERIC : 8'd0;
    assign intr_en_o = (state_q == ST_IDLE) || (state_q == ST_NERR);
    assign req_o     = (state_q == ST_SAVE) || (state_q == ST_RESTORE);
    assign wr_o      = (state_q == ST_SAVE);
    assign done_o    = (state_q == ST_DONE);

    // R2
    np_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && instr_i && flag_i) |=> (exc_o && exc_vec_o == VEC_NOT_PRESENT && !intr_en_o));

    // R5
    restore_order_chk: assert property (@(posedge clk) disable iff (rst)
        (req_o && wr_o && word_end) |=> (req_o && !wr_o));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && intr_en_o));

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SAVE && instr_i && !word_end) |=> (state_q == ST_SAVE && !exc_o));
endmodule

// File: rtl/cop_ctx_lazy.sv
module cop_ctx_lazy
    import cop_ctx_pkg::*;
#(
    parameter int unsigned TASK_W      = 4,
    parameter int unsigned STRIDE_LOG2 = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          task_switch_i,
    input  logic [TASK_W-1:0]             cur_task_i,
    input  logic                          cop_instr_i,
    input  logic                          cop_err_i,
    input  logic                          xfer_ack_i,
    output logic                          ts_flag_o,
    output logic [TASK_W-1:0]             owner_o,
    output logic                          exc_o,
    output logic [7:0]                    exc_vec_o,
    output logic                          intr_en_o,
    output logic                          xfer_req_o,
    output logic                          xfer_wr_o,
    output logic [TASK_W+STRIDE_LOG2-1:0] xfer_addr_o,
    output logic                          done_o
);
    seq_ctl_t          ctl;
    logic [TASK_W-1:0] tid;
    logic [TASK_W-1:0] area_tid;
    logic              err_hit;
    logic              last_word_w;

    cop_ts_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (task_switch_i),
        .clr_i  (ctl.clr_flag),
        .flag_o (ts_flag_o)
    );

    cop_owner_track #(.TASK_W(TASK_W)) u_owner (
        .clk        (clk),
        .rst        (rst),
        .load_i     (ctl.owner_load),
        .load_tid_i (tid),
        .err_i      (cop_err_i),
        .take_i     (ctl.take_err),
        .cur_task_i (cur_task_i),
        .owner_o    (owner_o),
        .err_hit_o  (err_hit)
    );

    cop_seq_fsm #(.TASK_W(TASK_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .instr_i    (cop_instr_i),
        .flag_i     (ts_flag_o),
        .cur_task_i (cur_task_i),
        .owner_i    (owner_o),
        .err_hit_i  (err_hit),
        .ack_i      (xfer_ack_i),
        .last_i     (last_word_w),
        .ctl_o      (ctl),
        .tid_o      (tid),
        .exc_o      (exc_o),
        .exc_vec_o  (exc_vec_o),
        .intr_en_o  (intr_en_o),
        .req_o      (xfer_req_o),
        .wr_o       (xfer_wr_o),
        .done_o     (done_o)
    );

    assign area_tid = xfer_wr_o ? owner_o : tid;

    cop_xfer_agu #(.TASK_W(TASK_W), .STRIDE_LOG2(STRIDE_LOG2)) u_agu (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (ctl.cnt_clr),
        .adv_i  (xfer_req_o && xfer_ack_i),
        .tid_i  (area_tid),
        .last_o (last_word_w),
        .addr_o (xfer_addr_o)
    );

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_req_o && !xfer_ack_i) |=> (xfer_req_o && $stable(xfer_addr_o) && $stable(xfer_wr_o)));
endmodule

// File: tb/cop_ctx_lazy_tb.sv
module cop_ctx_lazy_tb;
    localparam int TW = 4;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic          task_switch_i, cop_instr_i, cop_err_i, xfer_ack_i;
    logic [TW-1:0] cur_task_i;
    logic          ts_flag_o, exc_o, intr_en_o, xfer_req_o, xfer_wr_o, done_o;
    logic [TW-1:0] owner_o;
    logic [7:0]    exc_vec_o;
    logic [AW-1:0] xfer_addr_o;

    always #5 clk = ~clk;

    cop_ctx_lazy u_dut (
        .clk(clk), .rst(rst), .task_switch_i(task_switch_i), .cur_task_i(cur_task_i),
        .cop_instr_i(cop_instr_i), .cop_err_i(cop_err_i), .xfer_ack_i(xfer_ack_i),
        .ts_flag_o(ts_flag_o), .owner_o(owner_o), .exc_o(exc_o), .exc_vec_o(exc_vec_o),
        .intr_en_o(intr_en_o), .xfer_req_o(xfer_req_o), .xfer_wr_o(xfer_wr_o),
        .xfer_addr_o(xfer_addr_o), .done_o(done_o)
    );

    int vecs  = 0;
    int fails = 0;
    int cyc   = 0;
    int lat   = 0;
    int wcnt  = 0;
    logic [AW:0] exp_q[$];

    task automatic check_eq(input string tag, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor / acknowledge responder with 0..2 cycles of latency
    always @(negedge clk) begin
        if (rst) begin
            xfer_ack_i = 1'b0;
        end else if (xfer_ack_i) begin
            xfer_ack_i = 1'b0;
            lat  = (lat + 1) % 3;
            wcnt = lat;
        end else if (xfer_req_o) begin
            if (wcnt > 0) begin
                wcnt--;
            end else begin
                if (exp_q.size() == 0) begin
                    check_eq("R4/R5 unexpected transfer", int'({xfer_wr_o, xfer_addr_o}), -1);
                end else begin
                    logic [AW:0] e;
                    e = exp_q.pop_front();
                    check_eq("R4/R5/R6 transfer wr,addr", int'({xfer_wr_o, xfer_addr_o}), int'(e));
                end
                xfer_ack_i = 1'b1;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 50000) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    task automatic do_switch();
        task_switch_i = 1'b1;
        @(negedge clk);
        task_switch_i = 1'b0;
    endtask

    task automatic issue(input int tid);
        cur_task_i  = TW'(tid);
        cop_instr_i = 1'b1;
        @(negedge clk);
        cop_instr_i = 1'b0;
    endtask

    task automatic push_area(input bit wr, input int tid);
        for (int i = 0; i < 47; i++)
            exp_q.push_back({wr, AW'(tid * 256 + 44 + 2 * i)});
    endtask

    // not-present path; owner expected before, collision switch, stray instruction
    task automatic np_switch(input int tid, input int own, input bit sw_chk, input bit stray);
        bit bad_intr  = 0;
        bit extra_exc = 0;
        int k = 0;
        if (own != tid) begin
            push_area(1'b1, own);
            push_area(1'b0, tid);
        end
        issue(tid);
        check_eq("R2 exception strobe", int'(exc_o), 1);
        check_eq("R2 vector 7", int'(exc_vec_o), 7);
        check_eq("R2 interrupts inhibited", int'(intr_en_o), 0);
        if (sw_chk) task_switch_i = 1'b1;
        @(negedge clk);
        task_switch_i = 1'b0;
        if (own == tid) check_eq("R3 no transfer when owner matches", int'(xfer_req_o), 0);
        while (!done_o) begin
            if (intr_en_o) bad_intr = 1;
            if (exc_o) extra_exc = 1;
            cop_instr_i = (stray && k == 10);
            k++;
            @(negedge clk);
        end
        cop_instr_i = 1'b0;
        check_eq("R7 owner updated", int'(owner_o), tid);
        check_eq("R3 flag after check (R1 collision keeps it)", int'(ts_flag_o), sw_chk ? 1 : 0);
        check_eq("R2 intr low during sequence", int'(bad_intr), 0);
        if (stray) check_eq("R10 stray instruction ignored", int'(extra_exc), 0);
        @(negedge clk);
        check_eq("R8 done one cycle", int'(done_o), 0);
        check_eq("R8 interrupts back on", int'(intr_en_o), 1);
        check_eq("R5 all transfers consumed", exp_q.size(), 0);
    endtask

    task automatic plain_instr(input int tid, input bit exp16);
        issue(tid);
        if (exp16) begin
            check_eq("R9 numeric error reported", int'(exc_o), 1);
            check_eq("R9 vector 16", int'(exc_vec_o), 16);
        end else begin
            check_eq("R12/R9 no exception", int'(exc_o), 0);
            check_eq("R12 no transfer", int'(xfer_req_o), 0);
        end
        @(negedge clk);
        check_eq("R9 exception one cycle", int'(exc_o), 0);
    endtask

    initial begin
        rst = 1'b1;
        task_switch_i = 1'b0; cop_instr_i = 1'b0; cop_err_i = 1'b0;
        cur_task_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11
        check_eq("R11 flag", int'(ts_flag_o), 0);
        check_eq("R11 owner", int'(owner_o), 0);
        check_eq("R11 intr_en", int'(intr_en_o), 1);
        check_eq("R11 req", int'(xfer_req_o), 0);
        check_eq("R11 exc", int'(exc_o), 0);
        check_eq("R11 done", int'(done_o), 0);

        plain_instr(0, 1'b0);

        do_switch();
        check_eq("R1 flag set by switch", int'(ts_flag_o), 1);
        np_switch(0, 0, 1'b1, 1'b0);
        np_switch(0, 0, 1'b0, 1'b0);

        do_switch();
        np_switch(3, 0, 1'b0, 1'b0);

        cop_err_i = 1'b1;
        @(negedge clk);
        cop_err_i = 1'b0;
        do_switch();
        np_switch(5, 3, 1'b0, 1'b1);
        plain_instr(5, 1'b0);
        do_switch();
        np_switch(3, 5, 1'b0, 1'b0);
        plain_instr(3, 1'b1);
        plain_instr(3, 1'b0);

        do_switch();
        np_switch(15, 3, 1'b0, 1'b0);

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule